// File: doc/BRIEF.md
# USB Low/Full-Speed Receive Front End

This block turns the raw D+/D- pair of a low-speed or full-speed USB link into a byte stream. It is clocked at four times the bit rate, which is 48 MHz for full speed and 6 MHz for low speed. The two line inputs are asynchronous. They are resynchronised and classified each clock as J, K, single-ended zero or single-ended one. A digital phase-locked loop re-centres its sampling point on every line edge and produces one symbol strobe per bit.

The recovered symbols go through four steps in order. They are NRZI-decoded, stuffed bits are removed, the sync field is checked, and the data bits are packed LSB first into bytes. The output follows the usual receive-side handshake of a transceiver macrocell interface. One level shows that a packet is in progress. A one-cycle strobe comes with each byte. A one-cycle error strobe reports a stuffing violation, a packet that ends in the middle of a byte, or a malformed sync field. Transmit, high-speed signalling and packet parsing belong to other blocks.

Top module: `usbrx_front`

## Requirements
- R1: While reset is asserted, and afterwards on an idle J line, rx_active, rx_valid and rx_error are all low.
- R2: A packet made of the sync field, N whole bytes and an end of packet produces exactly N rx_valid pulses. Each pulse lasts one cycle and carries the bytes in order on rx_data. rx_data changes only in a cycle where rx_valid is high.
- R3: Decoding is NRZI: a bit period with no change of line level (J to J or K to K) is a 1, and a change between J and K is a 0. Bits are packed LSB first, so the first bit after sync becomes rx_data[0].
- R4: When six 1 bits have been decoded in a row, the next bit is a stuffed 0 and is discarded. Bytes of all ones (0xFF) are therefore received intact.
- R5: If a 1 follows six consecutive 1 bits, rx_error pulses for one cycle, and no further rx_valid is produced until the end of packet.
- R6: The sync field is the symbol sequence K J K J K J K K, which decodes to 0x80 (seven 0 bits, then a 1). Any other first eight decoded bits pulse rx_error, leave rx_active low, produce no bytes, and the receiver rearms after the following end of packet.
- R7: End of packet is at least one bit time of single-ended zero followed by a J bit. rx_active falls after that J, and the next K starts a new packet.
- R8: If end of packet arrives while 1 to 7 data bits of a byte are pending, rx_error pulses for one cycle while rx_active is still high. The whole bytes received before it are still delivered.
- R9: rx_active rises after a correct sync field and stays high until end of packet. rx_valid is only ever high while rx_active is high.
- R10: Every line edge re-centres the sampling phase. Data whose symbols alternate between three and five samples wide is decoded correctly.
- R11: In full-speed mode, J is D+ high with D- low and K is the reverse. A parameter swaps these for low-speed polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_dp | input | 1 | D+ line level, asynchronous |
| line_dm | input | 1 | D- line level, asynchronous |
| rx_active | output | 1 | High from a valid sync field to end of packet |
| rx_valid | output | 1 | One-cycle strobe qualifying rx_data |
| rx_data | output | 8 | Received byte, LSB was first on the wire |
| rx_error | output | 1 | One-cycle strobe on stuffing, alignment or sync error |

## Verification
The hardest case to reach from the ports is phase tracking under drift. It only shows up when symbols of unequal width come in long runs with no transitions, which the stuffing rule caps at seven bits. The stimulus sends 0xFF bytes and mixed patterns with every symbol alternately three and five samples wide, so the DPLL runs freely over the longest allowed run and must still pick exactly one sample per bit. The stuffing error is produced by bypassing the bench's own stuffing model and driving seven undecorated 1 bits directly after sync.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

   // Classified state of the differential pair
   typedef enum logic [1:0] {
      LS_SE0 = 2'd0,
      LS_J   = 2'd1,
      LS_K   = 2'd2,
      LS_SE1 = 2'd3
   } line_t;

   // Framing state machine
   typedef enum logic [2:0] {
      PK_IDLE,
      PK_SYNC,
      PK_DATA,
      PK_DRAIN,
      PK_EOPW
   } pk_state_t;

   localparam int          BYTE_W    = 8;
   localparam logic [7:0]  SYNC_CODE = 8'h80;

endpackage

// File: rtl/usbrx_line_sync.sv
module usbrx_line_sync
   import usbrx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit LOW_SPEED   = 1'b0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  dp_i,
   input  logic  dm_i,
   output line_t line_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("usbrx_line_sync: SYNC_STAGES must be at least 2");
   end

   // Idle (J) level of each wire for the chosen speed
   localparam logic IDLE_DP = LOW_SPEED ? 1'b0 : 1'b1;
   localparam logic IDLE_DM = LOW_SPEED ? 1'b1 : 1'b0;

   logic [SYNC_STAGES-1:0] dp_q;
   logic [SYNC_STAGES-1:0] dm_q;
   logic                   dp_s;
   logic                   dm_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_q <= {SYNC_STAGES{IDLE_DP}};
         dm_q <= {SYNC_STAGES{IDLE_DM}};
      end else begin
         dp_q <= {dp_q[SYNC_STAGES-2:0], dp_i};
         dm_q <= {dm_q[SYNC_STAGES-2:0], dm_i};
      end
   end

   assign dp_s = dp_q[SYNC_STAGES-1];
   assign dm_s = dm_q[SYNC_STAGES-1];

   if (LOW_SPEED) begin : g_ls_map
      always_comb begin
         unique case ({dp_s, dm_s})
            2'b00:   line_o = LS_SE0;
            2'b01:   line_o = LS_J;
            2'b10:   line_o = LS_K;
            default: line_o = LS_SE1;
         endcase
      end
   end else begin : g_fs_map
      always_comb begin
         unique case ({dp_s, dm_s})
            2'b00:   line_o = LS_SE0;
            2'b10:   line_o = LS_J;
            2'b01:   line_o = LS_K;
            default: line_o = LS_SE1;
         endcase
      end
   end

endmodule

// File: rtl/usbrx_dpll.sv
module usbrx_dpll
   import usbrx_pkg::*;
#(
   parameter int OVERSAMPLE = 4
)(
   input  logic  clk,
   input  logic  rst_n,
   input  line_t line_i,
   output logic  sym_vld_o,
   output line_t sym_o
);

   if (OVERSAMPLE < 3) begin : g_bad_ovs
      $error("usbrx_dpll: OVERSAMPLE must be at least 3");
   end

   localparam int            CW     = $clog2(OVERSAMPLE);
   localparam logic [CW-1:0] CENTRE = CW'(OVERSAMPLE / 2);
   localparam logic [CW-1:0] LAST   = CW'(OVERSAMPLE - 1);

   line_t         prev_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] phase;
   logic          chg;

   // A change of line state marks phase zero of a new symbol
   always_comb begin
      chg   = (line_i != prev_q);
      phase = chg ? '0 : cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= LS_J;
         cnt_q     <= '0;
         sym_vld_o <= 1'b0;
         sym_o     <= LS_J;
      end else begin
         prev_q    <= line_i;
         cnt_q     <= (phase == LAST) ? '0 : phase + 1'b1;
         sym_vld_o <= (phase == CENTRE);
         sym_o     <= line_i;
      end
   end

endmodule

// File: rtl/usbrx_nrzi_unstuff.sv
module usbrx_nrzi_unstuff
   import usbrx_pkg::*;
#(
   parameter int STUFF_RUN = 6
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clear_i,
   input  logic  sym_vld_i,
   input  line_t sym_i,
   output logic  bit_vld_o,
   output logic  bit_o,
   output logic  stuff_err_o,
   output logic  se0_o,
   output logic  j_o
);

   if (STUFF_RUN < 1) begin : g_bad_run
      $error("usbrx_nrzi_unstuff: STUFF_RUN must be positive");
   end

   localparam int OW = $clog2(STUFF_RUN + 1);
   localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);

   line_t         level_q;
   logic [OW-1:0] ones_q;
   logic          is_data;
   logic          dec;

   always_comb begin
      is_data = (sym_i == LS_J) || (sym_i == LS_K);
      dec     = (sym_i == level_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q     <= LS_J;
         ones_q      <= '0;
         bit_vld_o   <= 1'b0;
         bit_o       <= 1'b0;
         stuff_err_o <= 1'b0;
         se0_o       <= 1'b0;
         j_o         <= 1'b0;
      end else begin
         bit_vld_o   <= 1'b0;
         stuff_err_o <= 1'b0;
         se0_o       <= 1'b0;
         j_o         <= 1'b0;
         if (sym_vld_i) begin
            se0_o <= (sym_i == LS_SE0);
            j_o   <= (sym_i == LS_J);
            if (is_data) begin
               level_q <= sym_i;
               if (clear_i) begin
                  ones_q    <= '0;
                  bit_vld_o <= 1'b1;
                  bit_o     <= dec;
               end else if (ones_q == RUN_MAX) begin
                  ones_q      <= '0;
                  stuff_err_o <= dec;
               end else begin
                  ones_q    <= dec ? ones_q + 1'b1 : '0;
                  bit_vld_o <= 1'b1;
                  bit_o     <= dec;
               end
            end
         end
      end
   end

endmodule

// File: rtl/usbrx_framer.sv
module usbrx_framer
   import usbrx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              stuff_err_i,
   input  logic              se0_i,
   input  logic              j_i,
   output logic              clear_o,
   output logic              rx_active_o,
   output logic              rx_valid_o,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_error_o
);

   localparam int               CNT_W    = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   pk_state_t         state_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_nxt;
   logic [CNT_W-1:0]  cnt_q;

   assign sh_nxt  = {bit_i, sh_q[BYTE_W-1:1]};
   assign clear_o = (state_q == PK_IDLE) || (state_q == PK_DRAIN) ||
                    (state_q == PK_EOPW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PK_IDLE;
         sh_q        <= '0;
         cnt_q       <= '0;
         rx_active_o <= 1'b0;
         rx_valid_o  <= 1'b0;
         rx_data_o   <= '0;
         rx_error_o  <= 1'b0;
      end else begin
         rx_valid_o <= 1'b0;
         rx_error_o <= 1'b0;
         unique case (state_q)
            PK_IDLE: begin
               if (bit_vld_i && !bit_i) begin
                  sh_q    <= sh_nxt;
                  cnt_q   <= CNT_W'(1);
                  state_q <= PK_SYNC;
               end
            end
            PK_SYNC: begin
               if (se0_i) begin
                  rx_error_o <= 1'b1;
                  state_q    <= PK_EOPW;
               end else if (bit_vld_i) begin
                  sh_q <= sh_nxt;
                  if (cnt_q == LAST_BIT) begin
                     cnt_q <= '0;
                     if (sh_nxt == SYNC_CODE) begin
                        rx_active_o <= 1'b1;
                        state_q     <= PK_DATA;
                     end else begin
                        rx_error_o <= 1'b1;
                        state_q    <= PK_DRAIN;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PK_DATA: begin
               if (stuff_err_i) begin
                  rx_error_o <= 1'b1;
                  state_q    <= PK_DRAIN;
               end else if (se0_i) begin
                  rx_error_o <= (cnt_q != '0);
                  state_q    <= PK_EOPW;
               end else if (bit_vld_i) begin
                  sh_q <= sh_nxt;
                  if (cnt_q == LAST_BIT) begin
                     cnt_q      <= '0;
                     rx_data_o  <= sh_nxt;
                     rx_valid_o <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PK_DRAIN: begin
               if (se0_i) begin
                  state_q <= PK_EOPW;
               end
            end
            PK_EOPW: begin
               if (j_i) begin
                  rx_active_o <= 1'b0;
                  cnt_q       <= '0;
                  state_q     <= PK_IDLE;
               end
            end
            default: state_q <= PK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/usbrx_front.sv
module usbrx_front
   import usbrx_pkg::*;
#(
   parameter int OVERSAMPLE  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int STUFF_RUN   = 6,
   parameter bit LOW_SPEED   = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_dp,
   input  logic       line_dm,
   output logic       rx_active,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_error
);

   line_t line_s;
   logic  sym_vld;
   line_t sym;
   logic  clear;
   logic  bit_vld;
   logic  bit_val;
   logic  stuff_err;
   logic  se0_seen;
   logic  j_seen;

   usbrx_line_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .LOW_SPEED   (LOW_SPEED)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .dp_i   (line_dp),
      .dm_i   (line_dm),
      .line_o (line_s)
   );

   usbrx_dpll #(
      .OVERSAMPLE (OVERSAMPLE)
   ) u_dpll (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_s),
      .sym_vld_o (sym_vld),
      .sym_o     (sym)
   );

   usbrx_nrzi_unstuff #(
      .STUFF_RUN (STUFF_RUN)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear),
      .sym_vld_i   (sym_vld),
      .sym_i       (sym),
      .bit_vld_o   (bit_vld),
      .bit_o       (bit_val),
      .stuff_err_o (stuff_err),
      .se0_o       (se0_seen),
      .j_o         (j_seen)
   );

   usbrx_framer u_frm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_vld_i   (bit_vld),
      .bit_i       (bit_val),
      .stuff_err_i (stuff_err),
      .se0_i       (se0_seen),
      .j_i         (j_seen),
      .clear_o     (clear),
      .rx_active_o (rx_active),
      .rx_valid_o  (rx_valid),
      .rx_data_o   (rx_data),
      .rx_error_o  (rx_error)
   );

endmodule

// File: rtl/usbrx_front_chk.sv
module usbrx_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_active,
   input logic       rx_valid,
   input logic [7:0] rx_data,
   input logic       rx_error
);

   // R1: outputs quiet one cycle into reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!rx_active && !rx_valid && !rx_error));

   // R2: a byte strobe lasts a single cycle
   p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R2: data holds between strobes
   p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_data));

   // R9: bytes only inside an active packet
   p_valid_in_pkt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active);

   // R5: error is a one-cycle strobe
   p_error_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |=> !rx_error);

   // R6: a packet opens cleanly, never with an error or a byte
   p_clean_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> (!rx_error && !rx_valid));

endmodule

bind usbrx_front usbrx_front_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_active (rx_active),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .rx_error  (rx_error)
);

// File: tb/sim_usbrx_front.sv
module sim_usbrx_front;

   localparam int LV_SE0 = 0;
   localparam int LV_J   = 1;
   localparam int LV_K   = 2;
   localparam int NV     = 6;

   // {length, byte0, byte1, byte2, byte3}
   localparam logic [39:0] VTAB [NV] = '{
      40'h01_5A_00_00_00,
      40'h04_FF_FF_FF_FF,
      40'h02_00_00_00_00,
      40'h03_7E_3F_FC_00,
      40'h04_01_80_A5_C3,
      40'h02_FE_7F_00_00
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dp = 1'b1;
   logic       dm = 1'b0;
   logic       rx_active;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_error;

   always #2 clk = ~clk;

   usbrx_front u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_dp   (dp),
      .line_dm   (dm),
      .rx_active (rx_active),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_error  (rx_error)
   );

   int         n_chk = 0;
   int         n_fail = 0;
   int         n_got = 0;
   int         n_err = 0;
   bit         saw_active = 1'b0;
   bit         done = 1'b0;
   logic [7:0] got [16];
   int         cur = LV_J;
   int         ones = 0;

   always @(negedge clk) begin
      if (rx_valid && n_got < 16) begin
         got[n_got] = rx_data;
         n_got++;
      end
      if (rx_error) n_err++;
      if (rx_active) saw_active = 1'b1;
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(int lv, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         case (lv)
            LV_J:    begin dp = 1'b1; dm = 1'b0; end
            LV_K:    begin dp = 1'b0; dm = 1'b1; end
            default: begin dp = 1'b0; dm = 1'b0; end
         endcase
      end
   endtask

   task automatic send_raw(bit b, int n);
      if (!b) cur = (cur == LV_J) ? LV_K : LV_J;
      drive(cur, n);
   endtask

   task automatic send_bit(bit b, int n);
      send_raw(b, n);
      ones = b ? ones + 1 : 0;
      if (ones == 6) begin
         send_raw(1'b0, n);
         ones = 0;
      end
   endtask

   task automatic send_byte(logic [7:0] v, bit drift);
      for (int i = 0; i < 8; i++) begin
         send_bit(v[i], drift ? ((i % 2 == 0) ? 3 : 5) : 4);
      end
   endtask

   task automatic send_sync();
      drive(LV_K, 4); drive(LV_J, 4); drive(LV_K, 4); drive(LV_J, 4);
      drive(LV_K, 4); drive(LV_J, 4); drive(LV_K, 8);
      cur  = LV_K;
      ones = 1;
   endtask

   task automatic send_eop();
      drive(LV_SE0, 8);
      drive(LV_J, 4);
      cur = LV_J;
      drive(LV_J, 40);
   endtask

   task automatic clear_mon();
      @(negedge clk);
      n_got = 0;
      n_err = 0;
      saw_active = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      drive(LV_J, 10);
      chk(rx_active == 1'b0, "R1 active in reset", int'(rx_active), 0);
      chk(rx_valid == 1'b0, "R1 valid in reset", int'(rx_valid), 0);
      chk(rx_error == 1'b0, "R1 error in reset", int'(rx_error), 0);
      rst_n = 1'b1;
      clear_mon();
      drive(LV_J, 60);
      chk(rx_active == 1'b0, "R1 active idle", int'(rx_active), 0);
      chk(n_got == 0, "R1 no bytes idle", n_got, 0);
      chk(n_err == 0, "R1 no error idle", n_err, 0);

      // R2 R3 R4: vector table
      for (int v = 0; v < NV; v++) begin
         int len;
         len = int'(VTAB[v][39:32]);
         clear_mon();
         send_sync();
         for (int b = 0; b < len; b++) send_byte(VTAB[v][31-8*b -: 8], 1'b0);
         send_eop();
         chk(n_got == len, "R2 byte count", n_got, len);
         for (int b = 0; b < len; b++) begin
            chk(got[b] == VTAB[v][31-8*b -: 8],
                (VTAB[v][31:24] == 8'hFF || VTAB[v][31:24] == 8'hFE) ?
                   "R4 unstuffed byte" : "R3 decoded byte",
                int'(got[b]), int'(VTAB[v][31-8*b -: 8]));
         end
         chk(n_err == 0, "R2 no error", n_err, 0);
         chk(saw_active, "R9 active during packet", int'(saw_active), 1);
         chk(rx_active == 1'b0, "R7 active after EOP", int'(rx_active), 0);
      end

      // R5: stuffing violation
      clear_mon();
      send_sync();
      for (int i = 0; i < 7; i++) send_raw(1'b1, 4);
      ones = 0;
      send_byte(8'h12, 1'b0);
      send_byte(8'h34, 1'b0);
      send_eop();
      chk(n_err == 1, "R5 stuff error", n_err, 1);
      chk(n_got == 0, "R5 no bytes after error", n_got, 0);
      chk(rx_active == 1'b0, "R7 active after drained EOP", int'(rx_active), 0);

      // R8: EOP with partial byte
      clear_mon();
      send_sync();
      send_byte(8'h55, 1'b0);
      send_bit(1'b1, 4); send_bit(1'b0, 4); send_bit(1'b1, 4);
      send_eop();
      chk(n_got == 1, "R8 whole byte kept", n_got, 1);
      chk(got[0] == 8'h55, "R8 byte value", int'(got[0]), 8'h55);
      chk(n_err == 1, "R8 alignment error", n_err, 1);

      // R6: bad sync
      clear_mon();
      drive(LV_K, 4); drive(LV_J, 4); drive(LV_K, 4); drive(LV_J, 4);
      drive(LV_K, 4); drive(LV_J, 4); drive(LV_K, 4); drive(LV_J, 4);
      cur  = LV_J;
      ones = 0;
      send_byte(8'hA5, 1'b0);
      send_eop();
      chk(n_err == 1, "R6 sync error", n_err, 1);
      chk(n_got == 0, "R6 no bytes", n_got, 0);
      chk(saw_active == 1'b0, "R6 active stays low", int'(saw_active), 0);

      // R6 R7: recovery after bad sync
      clear_mon();
      send_sync();
      send_byte(8'h3C, 1'b0);
      send_eop();
      chk(n_got == 1 && got[0] == 8'h3C, "R7 rearmed packet", int'(got[0]), 8'h3C);
      chk(n_err == 0, "R6 no error after rearm", n_err, 0);

      // R10: drift, symbols 3 and 5 samples wide
      clear_mon();
      send_sync();
      send_byte(8'hC3, 1'b1);
      send_byte(8'hFF, 1'b1);
      send_byte(8'h0F, 1'b1);
      send_eop();
      chk(n_got == 3, "R10 drift byte count", n_got, 3);
      chk(got[0] == 8'hC3, "R10 drift byte0", int'(got[0]), 8'hC3);
      chk(got[1] == 8'hFF, "R10 drift byte1", int'(got[1]), 8'hFF);
      chk(got[2] == 8'h0F, "R10 drift byte2", int'(got[2]), 8'h0F);
      chk(n_err == 0, "R10 drift no error", n_err, 0);

      // R11: polarity, K is D+ low with D- high
      clear_mon();
      drive(LV_SE0, 0);
      send_sync();
      send_byte(8'h81, 1'b0);
      send_eop();
      chk(n_got == 1 && got[0] == 8'h81, "R11 full-speed polarity",
          int'(got[0]), 8'h81);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule